// File: doc/BRIEF.md
# Write-Broadcast Replicated Shared Memory

This block gives several processors conflict-free read access to one shared data set. It does not use multiport bit cells. Instead it keeps a full copy of the storage in each of several identical layers. Each layer is split into mats, and every mat has its own read/write port. A read is served only from the port's own mat, so all ports can read in the same cycle and never contend.

A write never goes straight into storage. The requesting port waits for a grant from a round-robin arbiter. The write then travels over a single shared broadcast bus, which carries a true line and a complement line. A five-phase sequencer runs it: precharge, source sense, bus drive, destination sense and cell writeback, one clock each. At the end of the writeback phase, the same mat index at the same address holds the new word in every layer. While a broadcast is running, `busy` is high and no new write is granted.

Ports are numbered `p = layer * MATS + mat`. The mat index of port `p` is `p % MATS`. A write through port `p` updates mat `p % MATS` in all layers. The defaults are 3 layers with 2 mats each (6 ports), 32 words per mat and 8-bit words.

Top module: `rbcast_shmem`

## Requirements
- R1: During reset and in the first cycle after it, `busy` is 0, `wr_gnt` is all zeros, both bus lines are all ones (precharged, equal), and every word of every mat reads 0.
- R2: At most one bit of `wr_gnt` is high in any cycle. `wr_gnt` is never high while `busy` is 1. When `busy` is 0 and any `wr_req` bit is high, exactly one requester gets its `wr_gnt` in that same cycle, and the write is taken on the next rising edge.
- R3: After each grant edge, `busy` is 1 for exactly 5 consecutive cycles and then returns to 0.
- R4: Once `busy` falls after a write through port `p` with address A and data D, every port of mat `p % MATS`, in every layer, reads D at address A.
- R5: While a broadcast is in progress, reads of its target address in any layer return the previous contents.
- R6: With several requests pending, grants go to the first requesting port at or after a rotating pointer, in increasing index order with wrap-around. The pointer starts at port 0 after reset and moves to the winner plus one after each grant.
- R7: In the second busy cycle, both bus lines are equal and all ones. In the fourth busy cycle, the true line carries D and the complement line carries ~D.
- R8: All ports can read different addresses in the same cycle, and each gets the correct word of its own mat.
- R9: A broadcast to one mat index leaves the other mat indices unchanged at every address.
- R10: A request that loses arbitration stays pending while its `wr_req` is held. It is granted later, and its data is broadcast like any other write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_req | input | NP | Per-port write request, held until granted |
| wr_addr | input | NP*AW | Per-port write address, port p at bits [p*AW +: AW] |
| wr_data | input | NP*DW | Per-port write data, port p at bits [p*DW +: DW] |
| wr_gnt | output | NP | One-hot grant, combinational, valid while idle |
| rd_addr | input | NP*AW | Per-port read address |
| rd_data | output | NP*DW | Per-port read data, combinational from the port's own mat |
| busy | output | 1 | A broadcast is in progress; writes are stalled |
| bus_t | output | DW | Registered broadcast bus, true line |
| bus_c | output | DW | Registered broadcast bus, complement line |

## Verification
Two functions can fall in the same cycle: a local read and a write broadcast to the same address, and a new write request and a broadcast still in progress. The bench keeps a port of another layer pointed at the target address for all five busy cycles. That read must still show the old word, and the new word must appear in every layer only once `busy` falls. The bench also raises all six requests at once and releases each one only after its grant. A scoreboard queue predicts the grant order from the rotating pointer, and a monitor flags any grant seen while `busy` is high.

// File: rtl/rbm_pkg.sv
package rbm_pkg;
    typedef enum logic [2:0] {
        PH_IDLE = 3'd0,
        PH_PRE  = 3'd1,
        PH_SRC  = 3'd2,
        PH_DRV  = 3'd3,
        PH_DST  = 3'd4,
        PH_WB   = 3'd5
    } phase_e;
endpackage

// File: rtl/rbm_rr_arb.sv
module rbm_rr_arb #(
    parameter int NP = 6,
    localparam int IW = (NP > 1) ? $clog2(NP) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          enable,
    input  logic [NP-1:0] req,
    output logic [NP-1:0] gnt,
    output logic [IW-1:0] gnt_idx
);
    typedef struct packed {
        logic [IW-1:0] ptr;
    } arb_state_t;

    arb_state_t st_q, st_d;

    always_comb begin
        logic found;
        st_d    = st_q;
        gnt     = '0;
        gnt_idx = '0;
        found   = 1'b0;
        for (int off = 0; off < NP; off++) begin
            int idx;
            idx = int'(st_q.ptr) + off;
            if (idx >= NP) idx = idx - NP;
            if (!found && enable && req[idx]) begin
                found    = 1'b1;
                gnt[idx] = 1'b1;
                gnt_idx  = IW'(idx);
            end
        end
        if (found) begin
            st_d.ptr = (int'(gnt_idx) == NP - 1) ? '0 : gnt_idx + IW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    p_onehot_gnt_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(gnt));
    p_grant_when_asked_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && (|req)) |-> (|(gnt & req)));
    p_no_grant_disabled_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |-> (gnt == '0));
endmodule

// File: rtl/rbm_seq.sv
module rbm_seq
    import rbm_pkg::*;
#(
    parameter int NP = 6,
    parameter int AW = 5,
    parameter int DW = 8,
    localparam int IW = (NP > 1) ? $clog2(NP) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [IW-1:0] start_idx,
    input  logic [AW-1:0] start_addr,
    input  logic [DW-1:0] start_data,
    input  logic [DW-1:0] src_sense,
    output phase_e        phase,
    output logic          busy,
    output logic [IW-1:0] pend_idx,
    output logic [AW-1:0] pend_addr,
    output logic [DW-1:0] pend_data,
    output logic [DW-1:0] bus_t,
    output logic [DW-1:0] bus_c
);
    typedef struct packed {
        phase_e        phase;
        logic [IW-1:0] idx;
        logic [AW-1:0] addr;
        logic [DW-1:0] data;
        logic [DW-1:0] bt;
        logic [DW-1:0] bc;
    } seq_state_t;

    seq_state_t st_q, st_d;

    always_comb begin
        st_d = st_q;
        unique case (st_q.phase)
            PH_IDLE: begin
                if (start) begin
                    st_d.phase = PH_PRE;
                    st_d.idx   = start_idx;
                    st_d.addr  = start_addr;
                    st_d.data  = start_data;
                end
            end
            PH_PRE: begin
                st_d.bt    = '1;
                st_d.bc    = '1;
                st_d.phase = PH_SRC;
            end
            PH_SRC: st_d.phase = PH_DRV;
            PH_DRV: begin
                st_d.bt    = src_sense;
                st_d.bc    = ~src_sense;
                st_d.phase = PH_DST;
            end
            PH_DST: st_d.phase = PH_WB;
            PH_WB:  st_d.phase = PH_IDLE;
            default: st_d.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q       <= '0;
            st_q.phase <= PH_IDLE;
            st_q.bt    <= '1;
            st_q.bc    <= '1;
        end else begin
            st_q <= st_d;
        end
    end

    assign phase     = st_q.phase;
    assign busy      = (st_q.phase != PH_IDLE);
    assign pend_idx  = st_q.idx;
    assign pend_addr = st_q.addr;
    assign pend_data = st_q.data;
    assign bus_t     = st_q.bt;
    assign bus_c     = st_q.bc;

    p_start_only_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> (st_q.phase == PH_IDLE));
    p_pre_to_src_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.phase == PH_PRE) |=> (st_q.phase == PH_SRC));
    p_src_to_drv_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.phase == PH_SRC) |=> (st_q.phase == PH_DRV));
    p_drv_to_dst_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.phase == PH_DRV) |=> (st_q.phase == PH_DST));
    p_dst_to_wb_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.phase == PH_DST) |=> (st_q.phase == PH_WB));
    p_wb_to_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.phase == PH_WB) |=> (st_q.phase == PH_IDLE));
    p_precharged_src_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.phase == PH_SRC) |-> (bus_t == bus_c));
    p_pending_stable_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && st_q.phase != PH_PRE) |-> $stable(pend_addr) && $stable(pend_idx));
endmodule

// File: rtl/rbm_mat.sv
module rbm_mat #(
    parameter int AW = 5,
    parameter int DW = 8,
    localparam int DEPTH = 1 << AW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          src_load,
    input  logic          dst_load,
    input  logic          wb_en,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    input  logic [DW-1:0] bus_t,
    input  logic [DW-1:0] bus_c,
    input  logic [AW-1:0] rd_addr,
    output logic [DW-1:0] rd_data,
    output logic [DW-1:0] sense
);
    typedef struct packed {
        logic [DEPTH-1:0][DW-1:0] mem;
        logic [DW-1:0]            sense;
    } mat_state_t;

    mat_state_t st_q, st_d;

    always_comb begin
        st_d = st_q;
        if (src_load) st_d.sense = wdata;
        if (dst_load) st_d.sense = bus_t;
        if (wb_en)    st_d.mem[addr] = st_q.sense;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rd_data = st_q.mem[rd_addr];
    assign sense   = st_q.sense;

    p_bus_driven_r7: assert property (@(posedge clk) disable iff (!rst_n)
        dst_load |-> (bus_t == ~bus_c));
    p_single_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !(src_load && dst_load));
    p_writeback_r4: assert property (@(posedge clk) disable iff (!rst_n)
        wb_en |=> (st_q.mem[$past(addr)] == $past(st_q.sense)));
    p_idle_keeps_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !wb_en |=> (st_q.mem == $past(st_q.mem)));
endmodule

// File: rtl/rbcast_shmem.sv
module rbcast_shmem
    import rbm_pkg::*;
#(
    parameter int LAYERS = 3,
    parameter int MATS   = 2,
    parameter int AW     = 5,
    parameter int DW     = 8,
    localparam int NP    = LAYERS * MATS,
    localparam int IW    = (NP > 1) ? $clog2(NP) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NP-1:0]    wr_req,
    input  logic [NP*AW-1:0] wr_addr,
    input  logic [NP*DW-1:0] wr_data,
    output logic [NP-1:0]    wr_gnt,
    input  logic [NP*AW-1:0] rd_addr,
    output logic [NP*DW-1:0] rd_data,
    output logic             busy,
    output logic [DW-1:0]    bus_t,
    output logic [DW-1:0]    bus_c
);
    logic [AW-1:0] waddr_a [NP];
    logic [DW-1:0] wdata_a [NP];
    logic [DW-1:0] sense_a [NP];
    logic [IW-1:0] gnt_idx;
    logic [IW-1:0] pend_idx;
    logic [AW-1:0] pend_addr;
    logic [DW-1:0] pend_data;
    logic [DW-1:0] src_sense;
    phase_e        phase;
    int            pend_layer;
    int            pend_mat;

    for (genvar p = 0; p < NP; p++) begin : g_unpack
        assign waddr_a[p] = wr_addr[p*AW +: AW];
        assign wdata_a[p] = wr_data[p*DW +: DW];
    end

    rbm_rr_arb #(.NP(NP)) u_arb (
        .clk     (clk),
        .rst_n   (rst_n),
        .enable  (phase == PH_IDLE),
        .req     (wr_req),
        .gnt     (wr_gnt),
        .gnt_idx (gnt_idx)
    );

    assign src_sense = sense_a[pend_idx];

    rbm_seq #(.NP(NP), .AW(AW), .DW(DW)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (|wr_gnt),
        .start_idx  (gnt_idx),
        .start_addr (waddr_a[gnt_idx]),
        .start_data (wdata_a[gnt_idx]),
        .src_sense  (src_sense),
        .phase      (phase),
        .busy       (busy),
        .pend_idx   (pend_idx),
        .pend_addr  (pend_addr),
        .pend_data  (pend_data),
        .bus_t      (bus_t),
        .bus_c      (bus_c)
    );

    assign pend_layer = int'(pend_idx) / MATS;
    assign pend_mat   = int'(pend_idx) % MATS;

    for (genvar l = 0; l < LAYERS; l++) begin : g_layer
        for (genvar m = 0; m < MATS; m++) begin : g_mat
            localparam int P = l * MATS + m;
            logic hit_mat;
            assign hit_mat = (pend_mat == m);
            rbm_mat #(.AW(AW), .DW(DW)) u_mat (
                .clk      (clk),
                .rst_n    (rst_n),
                .src_load ((phase == PH_SRC) && hit_mat && (pend_layer == l)),
                .dst_load ((phase == PH_DST) && hit_mat && (pend_layer != l)),
                .wb_en    ((phase == PH_WB) && hit_mat),
                .addr     (pend_addr),
                .wdata    (pend_data),
                .bus_t    (bus_t),
                .bus_c    (bus_c),
                .rd_addr  (rd_addr[P*AW +: AW]),
                .rd_data  (rd_data[P*DW +: DW]),
                .sense    (sense_a[P])
            );
        end
    end

    p_no_grant_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (wr_gnt == '0));
    p_grant_starts_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (|wr_gnt) |=> busy);
    p_bus_data_dst_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_DST) |-> (bus_t == pend_data) && (bus_c == ~pend_data));
endmodule

// File: tb/rbcast_shmem_tb_top.sv
module rbcast_shmem_tb_top;
    localparam int LAYERS = 3;
    localparam int MATS   = 2;
    localparam int AW     = 5;
    localparam int DW     = 8;
    localparam int NP     = LAYERS * MATS;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [NP-1:0]    wr_req = '0;
    logic [NP*AW-1:0] wr_addr = '0;
    logic [NP*DW-1:0] wr_data = '0;
    logic [NP-1:0]    wr_gnt;
    logic [NP*AW-1:0] rd_addr = '0;
    logic [NP*DW-1:0] rd_data;
    logic             busy;
    logic [DW-1:0]    bus_t, bus_c;

    int nchk = 0;
    int nfail = 0;
    int rr_ptr = 0;
    int exp_q[$];
    logic [DW-1:0] model [MATS][1<<AW];

    always #5 clk = ~clk;

    rbcast_shmem #(.LAYERS(LAYERS), .MATS(MATS), .AW(AW), .DW(DW)) dut_i (
        .clk(clk), .rst_n(rst_n), .wr_req(wr_req), .wr_addr(wr_addr),
        .wr_data(wr_data), .wr_gnt(wr_gnt), .rd_addr(rd_addr),
        .rd_data(rd_data), .busy(busy), .bus_t(bus_t), .bus_c(bus_c));

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [DW-1:0] rd(input int p);
        return rd_data[p*DW +: DW];
    endfunction

    task automatic read_chk(input int p, input int a, input logic [DW-1:0] e, input string tag);
        rd_addr[p*AW +: AW] = AW'(a);
        #1;
        chk(rd(p) == e, tag, 32'(rd(p)), 32'(e));
    endtask

    task automatic check_all(input int a);
        for (int l = 0; l < LAYERS; l++)
            for (int m = 0; m < MATS; m++)
                read_chk(l*MATS + m, a, model[m][a], "R4/R9 layer copy");
    endtask

    // scoreboard monitor: predicted grant order vs observed grants
    always @(negedge clk) begin
        if (rst_n) begin
            if (busy) chk(wr_gnt == '0, "R2 grant while busy", 32'(wr_gnt), 0);
            if (|wr_gnt) begin
                if (exp_q.size() == 0) chk(1'b0, "R2 unexpected grant", 32'(wr_gnt), 0);
                else begin
                    int e;
                    e = exp_q.pop_front();
                    chk(wr_gnt == NP'(1 << e), "R6 grant order", 32'(wr_gnt), 32'(1 << e));
                end
            end
        end
    end

    task automatic single_wr(input int p, input int a, input logic [DW-1:0] d);
        int o;
        int m;
        logic [DW-1:0] old;
        m = p % MATS;
        o = (p + MATS) % NP;
        old = model[m][a];
        @(posedge clk); #1;
        wr_req[p] = 1'b1;
        wr_addr[p*AW +: AW] = AW'(a);
        wr_data[p*DW +: DW] = d;
        rd_addr[o*AW +: AW] = AW'(a);
        exp_q.push_back(p);
        do @(negedge clk); while (!wr_gnt[p]);
        @(posedge clk); #1;
        wr_req[p] = 1'b0;
        for (int k = 0; k < 5; k++) begin
            @(negedge clk);
            chk(busy == 1'b1, "R3 busy during broadcast", 32'(busy), 1);
            chk(rd(o) == old, "R5 old data while in flight", 32'(rd(o)), 32'(old));
            if (k == 1) chk(bus_t == bus_c && bus_t == '1, "R7 precharged bus", 32'({bus_t, bus_c}), 32'({DW{1'b1}}) * 32'((1 << DW) + 1));
            if (k == 3) chk(bus_t == d && bus_c == ~d, "R7 driven bus", 32'({bus_t, bus_c}), 32'({d, ~d}));
        end
        @(negedge clk);
        chk(busy == 1'b0, "R3 busy released", 32'(busy), 0);
        model[m][a] = d;
        rr_ptr = (p + 1) % NP;
        check_all(a);
    endtask

    task automatic multi_wr(input logic [NP-1:0] mask, input int base, input logic [DW-1:0] seed);
        int left;
        left = 0;
        @(posedge clk); #1;
        for (int off = 0; off < NP; off++) begin
            int idx;
            idx = (rr_ptr + off) % NP;
            if (mask[idx]) begin
                exp_q.push_back(idx);
                left++;
            end
        end
        for (int p = 0; p < NP; p++) begin
            wr_addr[p*AW +: AW] = AW'(base + p);
            wr_data[p*DW +: DW] = seed + DW'(p * 17);
        end
        wr_req = mask;
        while (left > 0) begin
            int g;
            g = -1;
            @(negedge clk);
            for (int p = 0; p < NP; p++) if (wr_gnt[p]) g = p;
            if (g >= 0) begin
                @(posedge clk); #1;
                wr_req[g] = 1'b0;
                model[g % MATS][base + g] = seed + DW'(g * 17);
                rr_ptr = (g + 1) % NP;
                left--;
            end
        end
        while (busy) @(negedge clk);
        @(negedge clk);
        for (int p = 0; p < NP; p++)
            if (mask[p]) check_all(base + p);
        chk(exp_q.size() == 0, "R10 all pending granted", 32'(exp_q.size()), 0);
    endtask

    initial begin
        for (int m = 0; m < MATS; m++)
            for (int a = 0; a < (1 << AW); a++) model[m][a] = '0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        chk(busy == 1'b0, "R1 busy at reset", 32'(busy), 0);
        chk(wr_gnt == '0, "R1 no grant at reset", 32'(wr_gnt), 0);
        chk(bus_t == '1 && bus_c == '1, "R1 bus precharged", 32'({bus_t, bus_c}), 32'hFFFF);
        read_chk(0, 0, 8'h00, "R1 memory cleared");
        read_chk(5, 31, 8'h00, "R1 memory cleared");

        single_wr(0, 3, 8'hA5);
        single_wr(4, 3, 8'h3C);
        single_wr(3, 31, 8'hFF);
        single_wr(1, 0, 8'h81);
        read_chk(2, 0, model[0][0], "R9 other mat untouched");

        multi_wr(6'b111111, 8, 8'h10);
        multi_wr(6'b100100, 20, 8'h5A);

        @(posedge clk); #1;
        for (int p = 0; p < NP; p++) rd_addr[p*AW +: AW] = AW'(8 + p);
        #1;
        for (int p = 0; p < NP; p++)
            chk(rd(p) == model[p % MATS][8 + p], "R8 parallel reads", 32'(rd(p)), 32'(model[p % MATS][8 + p]));

        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end

    initial begin
        #2000000;
        nfail++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end
endmodule